// File: doc/BRIEF.md
# USB device bus suspend detector

This block watches the data-line activity of a full-speed USB device and decides when the bus has gone to sleep. An idle timer counts the clock-enable ticks during which the lines stay quiet. When the count reaches the 3 ms threshold, the block raises a suspend status bit and emits a one-cycle early-suspend interrupt. The status bit stays set until the lines become active again or software requests remote-wakeup signalling.

An erratic-error input takes a stronger path. It forces the suspended state at once, sets an erratic-error flag and locks the block in suspend. Bus activity and remote wakeup are then ignored. Only asserting the soft-disconnect control clears the lock. While soft disconnect is high, every flag and the timer are held cleared. Idle counting starts again from zero when soft disconnect is released. A constant speed-code output reports full speed.

Top module: `usb_suspend_det`

## Requirements
- R1: A synchronous active-high reset clears suspendSts, earlySuspIrq and erraticFlag by the cycle after reset is sampled.
- R2: With lineActive low, the idle count advances once for every cycle in which tickEn is high, and stops (saturates) at IDLE_LIMIT. suspendSts rises at the clock edge after the edge at which the count reaches IDLE_LIMIT. With tickEn high on every cycle from zero, suspendSts is therefore still low after IDLE_LIMIT cycles and high after IDLE_LIMIT+1.
- R3: Any cycle with lineActive high outside suspend restarts the idle count from zero.
- R4: Cycles with tickEn low do not advance the idle count.
- R5: Once set by the timer, suspendSts stays high for as long as lineActive and remoteWake stay low.
- R6: Outside the erratic lock, lineActive high during suspend clears suspendSts at the next edge. The idle count then restarts from zero.
- R7: Outside the erratic lock, remoteWake high during suspend clears suspendSts at the next edge.
- R8: earlySuspIrq is high for exactly one cycle, the cycle in which suspendSts goes from 0 to 1. It is not raised at any other time.
- R9: erraticErr high (with softDisconnect low) sets both suspendSts and erraticFlag at the next edge.
- R10: While erraticFlag is set, lineActive and remoteWake have no effect, and suspendSts stays high.
- R11: softDisconnect high clears suspendSts, erraticFlag and earlySuspIrq at the next edge and keeps them cleared. After it drops, a full IDLE_LIMIT idle period is again needed before suspend.
- R12: speedCode always reads binary 11 (full speed).
- R13: An erratic error arriving while the block is already suspended sets erraticFlag but raises no new earlySuspIrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (48 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Clock-enable tick for the idle timer |
| lineActive | input | 1 | Activity seen on the USB data lines this cycle |
| remoteWake | input | 1 | Software remote-wakeup signalling request |
| erraticErr | input | 1 | Erratic error report |
| softDisconnect | input | 1 | Soft-disconnect control; clears and holds the block idle |
| suspendSts | output | 1 | Suspend status |
| earlySuspIrq | output | 1 | One-cycle early-suspend interrupt |
| erraticFlag | output | 1 | Erratic-error suspend lock flag |
| speedCode | output | 2 | Enumerated speed code, 2'b11 |

## Verification
The bound checker tests these rules on every cycle: the interrupt coincides with the rising edge of the suspend status and never lasts two cycles; an erratic error forces and holds the lock; soft disconnect clears everything; and wake events release an unlocked suspend. The exact length of the idle window, the effect of missing ticks and the restart of the count after activity or disconnect are not visible to a per-cycle property. The bench's directed scenarios and its cycle-accurate reference model show these, since the model is compared against the outputs after every random step.

// File: rtl/usb_susp_pkg.sv
`timescale 1ns/1ps
package usb_susp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUSP = 2'd1,
    ST_LOCK = 2'd2
  } suspState_t;

  typedef struct packed {
    logic clrAll;
    logic clrCnt;
    logic incCnt;
    logic setSusp;
    logic wake;
    logic setLock;
    logic irqPulse;
  } suspStrobe_t;

  localparam logic [1:0] SPEED_FULL = 2'b11;

endpackage

// File: rtl/usb_susp_ctrl.sv
`timescale 1ns/1ps
module usb_susp_ctrl
  import usb_susp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tickEn,
  input  logic        lineActive,
  input  logic        remoteWake,
  input  logic        erraticErr,
  input  logic        softDisconnect,
  input  logic        atLimit,
  output suspStrobe_t strobe
);

  suspState_t state, stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    if (softDisconnect) begin
      strobe.clrAll = 1'b1;
      stateNxt      = ST_IDLE;
    end else begin
      unique case (state)
        ST_LOCK: begin
          stateNxt = ST_LOCK;
        end
        ST_SUSP: begin
          if (erraticErr) begin
            strobe.setLock = 1'b1;
            stateNxt       = ST_LOCK;
          end else if (lineActive || remoteWake) begin
            strobe.wake   = 1'b1;
            strobe.clrCnt = 1'b1;
            stateNxt      = ST_IDLE;
          end
        end
        default: begin
          if (erraticErr) begin
            strobe.setLock  = 1'b1;
            strobe.setSusp  = 1'b1;
            strobe.irqPulse = 1'b1;
            strobe.clrCnt   = 1'b1;
            stateNxt        = ST_LOCK;
          end else if (atLimit && !lineActive) begin
            strobe.setSusp  = 1'b1;
            strobe.irqPulse = 1'b1;
            stateNxt        = ST_SUSP;
          end else if (lineActive) begin
            strobe.clrCnt = 1'b1;
          end else if (tickEn && !atLimit) begin
            strobe.incCnt = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

endmodule

// File: rtl/usb_susp_dp.sv
`timescale 1ns/1ps
module usb_susp_dp
  import usb_susp_pkg::*;
#(
  parameter int IDLE_LIMIT = 144000
) (
  input  logic        clk,
  input  logic        rst,
  input  suspStrobe_t strobe,
  output logic        atLimit,
  output logic        suspReg,
  output logic        irqReg,
  output logic        errReg
);

  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(IDLE_LIMIT);

  logic [CNT_W-1:0] idleCnt;

  assign atLimit = (idleCnt == LIMIT_V);

  always_ff @(posedge clk) begin
    if (rst || strobe.clrAll) begin
      idleCnt <= '0;
    end else if (strobe.clrCnt) begin
      idleCnt <= '0;
    end else if (strobe.incCnt) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clrAll) begin
      suspReg <= 1'b0;
      irqReg  <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      irqReg <= strobe.irqPulse;
      if (strobe.setSusp)   suspReg <= 1'b1;
      else if (strobe.wake) suspReg <= 1'b0;
      if (strobe.setLock)   errReg  <= 1'b1;
    end
  end

endmodule

// File: rtl/usb_suspend_det.sv
`timescale 1ns/1ps
module usb_suspend_det
  import usb_susp_pkg::*;
#(
  parameter int IDLE_LIMIT = 144000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       lineActive,
  input  logic       remoteWake,
  input  logic       erraticErr,
  input  logic       softDisconnect,
  output logic       suspendSts,
  output logic       earlySuspIrq,
  output logic       erraticFlag,
  output logic [1:0] speedCode
);

  suspStrobe_t strobe;
  logic        atLimit;

  usb_susp_ctrl ctrl_i (
    .clk            (clk),
    .rst            (rst),
    .tickEn         (tickEn),
    .lineActive     (lineActive),
    .remoteWake     (remoteWake),
    .erraticErr     (erraticErr),
    .softDisconnect (softDisconnect),
    .atLimit        (atLimit),
    .strobe         (strobe)
  );

  usb_susp_dp #(.IDLE_LIMIT(IDLE_LIMIT)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .atLimit (atLimit),
    .suspReg (suspendSts),
    .irqReg  (earlySuspIrq),
    .errReg  (erraticFlag)
  );

  assign speedCode = SPEED_FULL;

endmodule

// File: rtl/usb_susp_chk.sv
`timescale 1ns/1ps
module usb_susp_chk (
  input logic clk,
  input logic rst,
  input logic lineActive,
  input logic remoteWake,
  input logic erraticErr,
  input logic softDisconnect,
  input logic suspendSts,
  input logic earlySuspIrq,
  input logic erraticFlag
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!suspendSts && !earlySuspIrq && !erraticFlag));

  p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(suspendSts) |-> earlySuspIrq);

  p_irq_only_rise_r8: assert property (@(posedge clk) disable iff (rst)
    earlySuspIrq |-> (suspendSts && !$past(suspendSts)));

  p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
    earlySuspIrq |=> !earlySuspIrq);

  p_err_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (erraticErr && !softDisconnect) |=> (suspendSts && erraticFlag));

  p_flag_in_susp_r9: assert property (@(posedge clk) disable iff (rst)
    erraticFlag |-> suspendSts);

  p_lock_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (erraticFlag && !softDisconnect) |=> (suspendSts && erraticFlag));

  p_sd_clears_r11: assert property (@(posedge clk) disable iff (rst)
    softDisconnect |=> (!suspendSts && !erraticFlag && !earlySuspIrq));

  p_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (suspendSts && !erraticFlag && !erraticErr && !softDisconnect
     && (lineActive || remoteWake)) |=> !suspendSts);

endmodule

bind usb_suspend_det usb_susp_chk chk_i (
  .clk            (clk),
  .rst            (rst),
  .lineActive     (lineActive),
  .remoteWake     (remoteWake),
  .erraticErr     (erraticErr),
  .softDisconnect (softDisconnect),
  .suspendSts     (suspendSts),
  .earlySuspIrq   (earlySuspIrq),
  .erraticFlag    (erraticFlag)
);

// File: tb/usb_suspend_det_tb_top.sv
`timescale 1ns/1ps
module usb_suspend_det_tb_top;

  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0, lineActive = 1'b0, remoteWake = 1'b0;
  logic erraticErr = 1'b0, softDisconnect = 1'b0;
  logic suspendSts, earlySuspIrq, erraticFlag;
  logic [1:0] speedCode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // reference model state
  int  mCnt  = 0;
  bit  mSusp = 0, mIrq = 0, mErr = 0, mLock = 0;

  always #2.5 clk = ~clk;

  usb_suspend_det #(.IDLE_LIMIT(LIM)) dut_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .lineActive(lineActive),
    .remoteWake(remoteWake), .erraticErr(erraticErr),
    .softDisconnect(softDisconnect), .suspendSts(suspendSts),
    .earlySuspIrq(earlySuspIrq), .erraticFlag(erraticFlag),
    .speedCode(speedCode)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void modelStep();
    if (rst || softDisconnect) begin
      mCnt = 0; mSusp = 0; mIrq = 0; mErr = 0; mLock = 0;
    end else if (mLock) begin
      mIrq = 0;
    end else if (erraticErr) begin
      mIrq = !mSusp; mSusp = 1; mLock = 1; mErr = 1; mCnt = 0;
    end else if (mSusp) begin
      mIrq = 0;
      if (lineActive || remoteWake) begin mSusp = 0; mCnt = 0; end
    end else begin
      mIrq = 0;
      if (mCnt == LIM && !lineActive) begin mSusp = 1; mIrq = 1; end
      else if (lineActive) mCnt = 0;
      else if (tickEn && mCnt < LIM) mCnt++;
    end
  endfunction

  task automatic step(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk(suspendSts,   mSusp, {tag, " suspendSts"});
    chk(earlySuspIrq, mIrq,  {tag, " earlySuspIrq"});
    chk(erraticFlag,  mErr,  {tag, " erraticFlag"});
    chk(speedCode,    3,     "R12 speedCode");
  endtask

  task automatic setIn(input bit t, input bit a, input bit w, input bit e, input bit s);
    tickEn = t; lineActive = a; remoteWake = w; erraticErr = e; softDisconnect = s;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish();
    end
  end

  initial begin
    @(negedge clk);
    step("R1 reset"); step("R1 reset");
    rst = 1'b0;
    chk(suspendSts, 0, "R1 suspendSts after reset");
    chk(earlySuspIrq, 0, "R1 irq after reset");
    chk(erraticFlag, 0, "R1 flag after reset");

    // R2: exact idle window
    setIn(1, 0, 0, 0, 0);
    for (int i = 0; i < LIM; i++) step("R2 idle");
    chk(suspendSts, 0, "R2 not yet suspended at LIM");
    step("R2 entry");
    chk(suspendSts, 1, "R2 suspended at LIM+1");
    chk(earlySuspIrq, 1, "R8 irq on entry");
    step("R5 hold");
    chk(earlySuspIrq, 0, "R8 irq single cycle");
    for (int i = 0; i < 10; i++) step("R5 hold");
    chk(suspendSts, 1, "R5 still suspended");

    // R6 activity wakes
    setIn(1, 1, 0, 0, 0); step("R6 wake");
    chk(suspendSts, 0, "R6 activity exit");

    // R3 restart
    setIn(1, 0, 0, 0, 0);
    for (int i = 0; i < 15; i++) step("R3 partial");
    setIn(1, 1, 0, 0, 0); step("R3 activity");
    setIn(1, 0, 0, 0, 0);
    for (int i = 0; i < LIM; i++) step("R3 recount");
    chk(suspendSts, 0, "R3 count restarted");
    step("R3 entry");
    chk(suspendSts, 1, "R3 suspend after full window");

    // R7 remote wake
    setIn(1, 0, 1, 0, 0); step("R7 wake");
    chk(suspendSts, 0, "R7 remote wake exit");

    // R4 tick gating
    setIn(0, 0, 0, 0, 0);
    for (int i = 0; i < 3 * LIM; i++) step("R4 no tick");
    chk(suspendSts, 0, "R4 no advance without tick");
    for (int i = 0; i < 2 * LIM + 2; i++) begin
      tickEn = (i % 2 == 0); step("R4 half ticks");
    end
    chk(suspendSts, 1, "R4 suspend after LIM ticks");

    // R13 erratic while suspended
    setIn(1, 0, 0, 1, 0); step("R13 erratic in susp");
    chk(erraticFlag, 1, "R13 flag set");
    chk(earlySuspIrq, 0, "R13 no new irq");

    // R10 lock
    setIn(1, 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) step("R10 lock");
    chk(suspendSts, 1, "R10 locked vs wake");

    // R11 soft disconnect
    setIn(1, 0, 0, 0, 1); step("R11 sd"); step("R11 sd");
    chk(suspendSts, 0, "R11 cleared");
    chk(erraticFlag, 0, "R11 flag cleared");

    // R9 erratic from idle
    setIn(1, 0, 0, 1, 0); step("R9 erratic");
    chk(suspendSts, 1, "R9 suspend");
    chk(erraticFlag, 1, "R9 flag");
    chk(earlySuspIrq, 1, "R9 irq from idle");
    setIn(1, 0, 0, 0, 1); step("R11 sd");
    setIn(1, 0, 0, 0, 0);
    for (int i = 0; i < LIM; i++) step("R11 recount");
    chk(suspendSts, 0, "R11 full window after release");
    step("R11 entry");

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      setIn(($urandom % 4) != 0, ($urandom % 40) == 0, ($urandom % 60) == 0,
            ($urandom % 400) == 0, ($urandom % 300) == 0);
      step("R2/R5/R6/R7/R8/R10 random");
    end
    finish();
  end

endmodule